// File: doc/BRIEF.md
# Serial DAC Frame Loader

This controller runs on the system clock and moves a 12-bit code into an external three-wire serial converter that has its own load and clear strobes. A write arrives on a valid/ready channel together with its data; a clear arrives on a second valid/ready channel. For a write, the block lowers chip select and shifts out a 16-bit frame as two 8-bit bytes, most significant bit first. The frame is four zero padding bits followed by the 12 data bits. The serial clock idles high and the receiver samples on its rising edge. After the frame, chip select is released while the clock is high. The load strobe then pulses low in a phase of its own.

Every minimum time on the converter pins is set by a parameter in picoseconds. The controller turns each one into clock cycles, rounding up, and counts it out. A clear drives the clear strobe low for its minimum width. If the clear is requested while a write is running, it is held and carried out once the load phase has finished, so the converter ends at zero. A one-cycle done pulse marks the return to idle.

Top module: `dacld_top`

## Requirements
- R1: After reset, dac_sclk, dac_cs_n, dac_ldac_n and dac_clr_n are high, done is low, and wr_ready and clr_ready are high.
- R2: A write is taken on a clock edge where wr_valid and wr_ready are both high. wr_ready stays low from that edge until done. When wr_valid and clr_valid are both high in idle, wr_ready is low and the clear is taken.
- R3: A write frame has exactly 16 rising dac_sclk edges while dac_cs_n is low, sampled most significant bit first. The first 4 bits are 0, then wr_data[11] down to wr_data[0]. dac_sdin keeps its value during the cycle before each rising edge.
- R4: dac_sclk is high whenever dac_cs_n is high. Each low phase lasts at least max(ceil(T_LO/CLK), ceil(T_DS/CLK)) cycles. Each high phase between two falling edges lasts at least max(ceil(T_HI/CLK), ceil(T_DH/CLK)) cycles.
- R5: dac_cs_n is low for at least ceil(T_CSS/CLK) cycles before the first falling edge of dac_sclk.
- R6: Between the two bytes, dac_cs_n stays low and dac_sclk stays high for at least BYTE_GAP_CYC cycles more than the minimum high phase.
- R7: dac_cs_n rises only in a cycle where dac_sclk is high and was also high in the cycle before.
- R8: dac_ldac_n falls only while dac_cs_n is high, and at least ceil(T_LD1/CLK) cycles after it rose. It stays low at least ceil(T_LDW/CLK) cycles. dac_cs_n falls again only once dac_ldac_n has been high at least ceil(T_LD2/CLK) cycles and dac_cs_n has been high at least ceil(T_DES/CLK) cycles.
- R9: A clear taken in idle drives dac_clr_n low for at least ceil(T_CLRW/CLK) cycles, with no activity on dac_sclk, dac_cs_n or dac_ldac_n.
- R10: A clear taken during a write is held. dac_clr_n falls only after dac_ldac_n has returned high, and never while dac_cs_n or dac_ldac_n is low. clr_ready is low while a clear is held or being driven.
- R11: done is high for exactly one cycle each time the controller returns to idle. A write together with a held clear gives a single done pulse.
- R12: Every phase count is the parameter in picoseconds divided by CLK_PS and rounded up, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_valid | input | 1 | Write request valid |
| wr_data | input | DATA_W | Code to send to the converter |
| wr_ready | output | 1 | Controller can take a write |
| clr_valid | input | 1 | Clear request valid |
| clr_ready | output | 1 | Controller can take a clear |
| done | output | 1 | One-cycle pulse when a sequence completes |
| dac_sclk | output | 1 | Serial clock to the converter, idles high |
| dac_sdin | output | 1 | Serial data to the converter |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_ldac_n | output | 1 | Active-low load strobe |
| dac_clr_n | output | 1 | Active-low clear strobe |

## Verification
The properties assume that wr_valid, wr_data and clr_valid change in step with clk, and that reset is asserted before the first request. They also assume that a request, once raised, is not withdrawn while the controller is still deciding whether to take it. The stimulus sets every request on the falling clock edge. It raises a request only while the matching ready is known to be high and drops it one cycle later. It keeps wr_data fixed during that cycle. The held-clear case places the clear in the middle of a frame, after a few bits have gone out.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CSS,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_LDS,
        ST_LDW,
        ST_LDH,
        ST_DESEL,
        ST_CLR
    } dacld_st_e;

    typedef struct packed {
        dacld_st_e st;
        logic      sclk;
        logic      cs_n;
        logic      ldac_n;
        logic      clr_n;
        logic      done;
        logic      clr_pend;
    } dacld_ctl_t;

    // Convert a time in ps to clock cycles, rounded up, at least one cycle.
    function automatic int cyc_ceil(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacld_timer.sv
module dacld_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dacld_shift.sv
module dacld_shift #(
    parameter int FRAME_W = 16,
    parameter int BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_val,
    input  logic               shift,
    output logic               bit_o,
    output logic               last_o,
    output logic               byte_end_o
);

    localparam int IDX_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam int BC_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);
    localparam logic [BC_W-1:0]  BC_LAST  = BC_W'(BYTE_W - 1);

    logic [FRAME_W-1:0] sh_d, sh_q;
    logic [IDX_W-1:0]   idx_d, idx_q;
    logic [BC_W-1:0]    bc_d, bc_q;

    always_comb begin
        sh_d  = sh_q;
        idx_d = idx_q;
        bc_d  = bc_q;
        if (load) begin
            sh_d  = load_val;
            idx_d = '0;
            bc_d  = '0;
        end else if (shift) begin
            sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
            idx_d = idx_q + 1'b1;
            bc_d  = (bc_q == BC_LAST) ? '0 : bc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
            bc_q  <= '0;
        end else begin
            sh_q  <= sh_d;
            idx_q <= idx_d;
            bc_q  <= bc_d;
        end
    end

    assign bit_o      = sh_q[FRAME_W-1];
    assign last_o     = (idx_q == IDX_LAST);
    assign byte_end_o = (bc_q == BC_LAST);

endmodule

// File: rtl/dacld_top.sv
module dacld_top
    import dacld_pkg::*;
#(
    parameter int DATA_W       = 12,
    parameter int BYTE_W       = 8,
    parameter int NBYTES       = 2,
    parameter int CLK_PS       = 10000,
    parameter int T_HI_PS      = 30000,
    parameter int T_LO_PS      = 30000,
    parameter int T_DS_PS      = 15000,
    parameter int T_DH_PS      = 15000,
    parameter int T_CSS_PS     = 30000,
    parameter int T_DES_PS     = 20000,
    parameter int T_LD1_PS     = 15000,
    parameter int T_LDW_PS     = 20000,
    parameter int T_LD2_PS     = 10000,
    parameter int T_CLRW_PS    = 30000,
    parameter int BYTE_GAP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              clr_valid,
    output logic              clr_ready,
    output logic              done,
    output logic              dac_sclk,
    output logic              dac_sdin,
    output logic              dac_cs_n,
    output logic              dac_ldac_n,
    output logic              dac_clr_n
);

    localparam int FRAME_W = BYTE_W * NBYTES;
    localparam int PAD_W   = FRAME_W - DATA_W;

    localparam int N_HI   = imax(cyc_ceil(T_HI_PS, CLK_PS), cyc_ceil(T_DH_PS, CLK_PS));
    localparam int N_LO   = imax(cyc_ceil(T_LO_PS, CLK_PS), cyc_ceil(T_DS_PS, CLK_PS));
    localparam int N_CSS  = cyc_ceil(T_CSS_PS, CLK_PS);
    localparam int N_DES  = cyc_ceil(T_DES_PS, CLK_PS);
    localparam int N_LD1  = cyc_ceil(T_LD1_PS, CLK_PS);
    localparam int N_LDW  = cyc_ceil(T_LDW_PS, CLK_PS);
    localparam int N_LD2  = cyc_ceil(T_LD2_PS, CLK_PS);
    localparam int N_CLRW = cyc_ceil(T_CLRW_PS, CLK_PS);
    localparam int N_GAP  = imax(1, BYTE_GAP_CYC);
    localparam int N_MAX  = imax(imax(imax(N_HI, N_LO), imax(N_CSS, N_DES)),
                                 imax(imax(N_LD1, N_LDW), imax(imax(N_LD2, N_CLRW), N_GAP)));
    localparam int CNT_W  = $clog2(N_MAX + 1);

    dacld_ctl_t c_d, c_q;

    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_zero;
    logic               sh_load;
    logic               sh_shift;
    logic               sh_bit;
    logic               sh_last;
    logic               sh_byte_end;
    logic [FRAME_W-1:0] frame;
    logic               wr_fire;
    logic               clr_fire;

    // Frame assembly: padding goes in front of the data word.
    generate
        if (PAD_W > 0) begin : g_pad
            assign frame = {{PAD_W{1'b0}}, wr_data};
        end else begin : g_nopad
            assign frame = wr_data;
        end
    endgenerate

    function automatic logic [CNT_W-1:0] phase_len_m1(input dacld_st_e s);
        int n;
        case (s)
            ST_CSS:   n = N_CSS;
            ST_LOW:   n = N_LO;
            ST_HIGH:  n = N_HI;
            ST_GAP:   n = N_GAP;
            ST_LDS:   n = N_LD1;
            ST_LDW:   n = N_LDW;
            ST_LDH:   n = N_LD2;
            ST_DESEL: n = N_DES;
            ST_CLR:   n = N_CLRW;
            default:  n = 1;
        endcase
        return CNT_W'(n - 1);
    endfunction

    assign wr_ready  = (c_q.st == ST_IDLE) && !clr_valid;
    assign clr_ready = (c_q.st != ST_CLR) && !c_q.clr_pend;
    assign wr_fire   = wr_valid && wr_ready;
    assign clr_fire  = clr_valid && clr_ready;

    always_comb begin
        c_d      = c_q;
        sh_load  = 1'b0;
        sh_shift = 1'b0;

        case (c_q.st)
            ST_IDLE: begin
                if (clr_fire) begin
                    c_d.st = ST_CLR;
                end else if (wr_fire) begin
                    c_d.st  = ST_CSS;
                    sh_load = 1'b1;
                end
            end
            ST_CSS: begin
                if (tmr_zero) c_d.st = ST_LOW;
            end
            ST_LOW: begin
                if (tmr_zero) c_d.st = ST_HIGH;
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    sh_shift = 1'b1;
                    if (sh_last) begin
                        c_d.st = ST_LDS;
                    end else if (sh_byte_end) begin
                        c_d.st = ST_GAP;
                    end else begin
                        c_d.st = ST_LOW;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_zero) c_d.st = ST_LOW;
            end
            ST_LDS: begin
                if (tmr_zero) c_d.st = ST_LDW;
            end
            ST_LDW: begin
                if (tmr_zero) c_d.st = ST_LDH;
            end
            ST_LDH: begin
                if (tmr_zero) c_d.st = ST_DESEL;
            end
            ST_DESEL: begin
                if (tmr_zero) begin
                    if (c_q.clr_pend || clr_fire) begin
                        c_d.st       = ST_CLR;
                        c_d.clr_pend = 1'b0;
                    end else begin
                        c_d.st = ST_IDLE;
                    end
                end
            end
            ST_CLR: begin
                if (tmr_zero) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase

        // A clear that cannot start now is held until the load phase ends.
        if (clr_fire && (c_q.st != ST_IDLE) && (c_d.st != ST_CLR)) begin
            c_d.clr_pend = 1'b1;
        end

        // Pin levels follow the phase being entered.
        c_d.sclk   = (c_d.st != ST_LOW);
        c_d.cs_n   = !((c_d.st == ST_CSS) || (c_d.st == ST_LOW) ||
                       (c_d.st == ST_HIGH) || (c_d.st == ST_GAP));
        c_d.ldac_n = (c_d.st != ST_LDW);
        c_d.clr_n  = (c_d.st != ST_CLR);
        c_d.done   = (c_d.st == ST_IDLE) && (c_q.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st       <= ST_IDLE;
            c_q.sclk     <= 1'b1;
            c_q.cs_n     <= 1'b1;
            c_q.ldac_n   <= 1'b1;
            c_q.clr_n    <= 1'b1;
            c_q.done     <= 1'b0;
            c_q.clr_pend <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign tmr_load = (c_d.st != c_q.st);
    assign tmr_val  = phase_len_m1(c_d.st);

    dacld_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero_o   (tmr_zero)
    );

    dacld_shift #(
        .FRAME_W (FRAME_W),
        .BYTE_W  (BYTE_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sh_load),
        .load_val   (frame),
        .shift      (sh_shift),
        .bit_o      (sh_bit),
        .last_o     (sh_last),
        .byte_end_o (sh_byte_end)
    );

    assign done       = c_q.done;
    assign dac_sclk   = c_q.sclk;
    assign dac_sdin   = sh_bit;
    assign dac_cs_n   = c_q.cs_n;
    assign dac_ldac_n = c_q.ldac_n;
    assign dac_clr_n  = c_q.clr_n;

endmodule

// File: rtl/dacld_chk.sv
module dacld_chk #(
    parameter int N_LO   = 3,
    parameter int N_CSS  = 3,
    parameter int N_DES  = 2,
    parameter int N_LD1  = 2,
    parameter int N_LDW  = 2,
    parameter int N_CLRW = 3
) (
    input logic clk,
    input logic rst_n,
    input logic wr_ready,
    input logic clr_ready,
    input logic done,
    input logic sclk,
    input logic sdin,
    input logic cs_n,
    input logic ldac_n,
    input logic clr_n
);

    localparam int SAT = 1 << 20;

    int lo_q, cs_lo_q, cs_hi_q, ldac_lo_q, clr_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q      <= 0;
            cs_lo_q   <= 0;
            cs_hi_q   <= SAT;
            ldac_lo_q <= 0;
            clr_lo_q  <= 0;
        end else begin
            lo_q      <= sclk   ? 0 : ((lo_q < SAT) ? lo_q + 1 : lo_q);
            cs_lo_q   <= cs_n   ? 0 : ((cs_lo_q < SAT) ? cs_lo_q + 1 : cs_lo_q);
            cs_hi_q   <= !cs_n  ? 0 : ((cs_hi_q < SAT) ? cs_hi_q + 1 : cs_hi_q);
            ldac_lo_q <= ldac_n ? 0 : ((ldac_lo_q < SAT) ? ldac_lo_q + 1 : ldac_lo_q);
            clr_lo_q  <= clr_n  ? 0 : ((clr_lo_q < SAT) ? clr_lo_q + 1 : clr_lo_q);
        end
    end

    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !wr_ready);

    p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdin));

    p_idle_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    p_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (lo_q >= N_LO));

    p_cs_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (cs_lo_q >= N_CSS));

    p_cs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (sclk && $past(sclk)));

    p_ldac_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_n |-> cs_n);

    p_ldac_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ldac_n) |-> (cs_hi_q >= N_LD1));

    p_ldac_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldac_n) |-> (ldac_lo_q >= N_LDW));

    p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (cs_hi_q >= N_DES));

    p_clr_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_n) |-> (clr_lo_q >= N_CLRW));

    p_clr_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (cs_n && ldac_n && !clr_ready));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind dacld_top dacld_chk #(
    .N_LO   (N_LO),
    .N_CSS  (N_CSS),
    .N_DES  (N_DES),
    .N_LD1  (N_LD1),
    .N_LDW  (N_LDW),
    .N_CLRW (N_CLRW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ready  (wr_ready),
    .clr_ready (clr_ready),
    .done      (done),
    .sclk      (dac_sclk),
    .sdin      (dac_sdin),
    .cs_n      (dac_cs_n),
    .ldac_n    (dac_ldac_n),
    .clr_n     (dac_clr_n)
);

// File: tb/sim_dacld_top.sv
`timescale 1ns/1ps
module sim_dacld_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_PS     = 10000;
    localparam int GAP        = 2;

    function automatic int up(input int t_ps);
        int c;
        c = (t_ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected phase counts for the default parameters (R12).
    localparam int E_HI   = mx(up(30000), up(15000));
    localparam int E_LO   = mx(up(30000), up(15000));
    localparam int E_CSS  = up(30000);
    localparam int E_DES  = up(20000);
    localparam int E_LD1  = up(15000);
    localparam int E_LDW  = up(20000);
    localparam int E_LD2  = up(10000);
    localparam int E_CLRW = up(30000);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [11:0] wr_data = '0;
    logic        clr_valid = 1'b0;
    logic        wr_ready, clr_ready, done;
    logic        dac_sclk, dac_sdin, dac_cs_n, dac_ldac_n, dac_clr_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dacld_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .clr_valid  (clr_valid),
        .clr_ready  (clr_ready),
        .done       (done),
        .dac_sclk   (dac_sclk),
        .dac_sdin   (dac_sdin),
        .dac_cs_n   (dac_cs_n),
        .dac_ldac_n (dac_ldac_n),
        .dac_clr_n  (dac_clr_n)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input string what, input int act, input int lim);
        n_chk++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
        end
    endtask

    // Pin monitor, sampled on the falling edge: one sample per cycle.
    logic        p_sclk = 1'b1, p_cs = 1'b1, p_ldac = 1'b1, p_clr = 1'b1, p_sdin = 1'b0;
    int          cyc = 0;
    int          lo_run = 0, hi_run = 0, cs_lo_run = 0, cs_hi_run = 1000;
    int          ldac_lo_run = 0, since_ldac_up = 1000, clr_lo_run = 0;
    logic [15:0] cap = '0, last_frame = '0;
    int          nbits = 0, last_nbits = 0, frames = 0;
    int          ldac_pulses = 0, clr_pulses = 0, done_cnt = 0;
    int          t_ldac_up = 0, t_clr_down = 0, gap_hi = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (dac_sclk && !p_sclk) begin
                chk_eq("R4", "rising sclk inside frame", int'(dac_cs_n), 0);
                chk_ge("R4", "sclk low cycles", lo_run, E_LO);
                chk_eq("R3", "sdin stable into rising edge", int'(dac_sdin), int'(p_sdin));
                cap = {cap[14:0], dac_sdin};
                nbits++;
            end
            if (!dac_sclk && p_sclk) begin
                chk_eq("R4", "falling sclk inside frame", int'(dac_cs_n), 0);
                if (nbits == 0) chk_ge("R5", "cs setup cycles", cs_lo_run, E_CSS);
                else chk_ge("R4", "sclk high cycles", hi_run, E_HI);
                if (nbits == 8) gap_hi = hi_run;
            end
            if (!dac_cs_n && p_cs) begin
                chk_ge("R8", "deselect cycles", cs_hi_run, E_DES);
                chk_ge("R8", "load hold cycles", since_ldac_up, E_LD2);
                cap = '0;
                nbits = 0;
            end
            if (dac_cs_n && !p_cs) begin
                chk_eq("R7", "sclk high at cs release", int'(dac_sclk && p_sclk), 1);
                last_frame = cap;
                last_nbits = nbits;
                frames++;
            end
            if (!dac_ldac_n && p_ldac) begin
                chk_eq("R8", "cs high at load", int'(dac_cs_n), 1);
                chk_ge("R8", "load setup cycles", cs_hi_run, E_LD1);
            end
            if (dac_ldac_n && !p_ldac) begin
                chk_ge("R8", "load width cycles", ldac_lo_run, E_LDW);
                ldac_pulses++;
                t_ldac_up = cyc;
            end
            if (!dac_clr_n && p_clr) begin
                chk_eq("R10", "clear outside frame and load", int'(dac_cs_n && dac_ldac_n), 1);
                t_clr_down = cyc;
            end
            if (dac_clr_n && !p_clr) begin
                chk_ge("R9", "clear width cycles", clr_lo_run, E_CLRW);
                clr_pulses++;
            end
            if (done) done_cnt++;

            lo_run        = dac_sclk   ? 0 : lo_run + 1;
            hi_run        = dac_sclk   ? hi_run + 1 : 0;
            cs_lo_run     = dac_cs_n   ? 0 : cs_lo_run + 1;
            cs_hi_run     = dac_cs_n   ? cs_hi_run + 1 : 0;
            ldac_lo_run   = dac_ldac_n ? 0 : ldac_lo_run + 1;
            since_ldac_up = dac_ldac_n ? since_ldac_up + 1 : 0;
            clr_lo_run    = dac_clr_n  ? 0 : clr_lo_run + 1;
        end
        p_sclk = dac_sclk;
        p_cs   = dac_cs_n;
        p_ldac = dac_ldac_n;
        p_clr  = dac_clr_n;
        p_sdin = dac_sdin;
    end

    task automatic wait_done(output int busy_ready);
        busy_ready = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (!dac_cs_n && wr_ready) busy_ready = 1;
            if (done) break;
        end
        chk_eq("R11", "done seen", int'(done), 1);
        @(negedge clk);
        chk_eq("R11", "done lasts one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        chk_eq("R1", "sclk", int'(dac_sclk), 1);
        chk_eq("R1", "cs_n", int'(dac_cs_n), 1);
        chk_eq("R1", "ldac_n", int'(dac_ldac_n), 1);
        chk_eq("R1", "clr_n", int'(dac_clr_n), 1);
        chk_eq("R1", "done", int'(done), 0);
        chk_eq("R1", "wr_ready", int'(wr_ready), 1);
        chk_eq("R1", "clr_ready", int'(clr_ready), 1);
    endtask

    task automatic t_write(input logic [11:0] val);
        int f0, l0, d0, busy;
        f0 = frames; l0 = ldac_pulses; d0 = done_cnt;
        @(negedge clk);
        chk_eq("R2", "ready before write", int'(wr_ready), 1);
        wr_valid = 1'b1;
        wr_data  = val;
        @(negedge clk);
        wr_valid = 1'b0;
        chk_eq("R2", "ready low after accept", int'(wr_ready), 0);
        wait_done(busy);
        chk_eq("R2", "ready low during frame", busy, 0);
        chk_eq("R2", "ready back after done", int'(wr_ready), 1);
        chk_eq("R3", "one frame sent", frames - f0, 1);
        chk_eq("R3", "rising edges per frame", last_nbits, 16);
        chk_eq("R3", "data bits msb first", int'(last_frame[11:0]), int'(val));
        chk_eq("R3", "padding bits", int'(last_frame[15:12]), 0);
        chk_ge("R6", "byte gap high cycles", gap_hi, E_HI + GAP);
        chk_eq("R8", "one load pulse", ldac_pulses - l0, 1);
        chk_eq("R11", "one done per write", done_cnt - d0, 1);
    endtask

    task automatic t_clear_idle();
        int f0, l0, c0, busy;
        f0 = frames; l0 = ldac_pulses; c0 = clr_pulses;
        @(negedge clk);
        clr_valid = 1'b1;
        @(negedge clk);
        clr_valid = 1'b0;
        chk_eq("R9", "clear strobe low", int'(dac_clr_n), 0);
        chk_eq("R9", "cs stays high", int'(dac_cs_n), 1);
        wait_done(busy);
        chk_eq("R9", "one clear pulse", clr_pulses - c0, 1);
        chk_eq("R9", "no frame on clear", frames - f0, 0);
        chk_eq("R9", "no load on clear", ldac_pulses - l0, 0);
    endtask

    task automatic t_both_idle();
        int f0, c0, busy;
        f0 = frames; c0 = clr_pulses;
        @(negedge clk);
        wr_valid  = 1'b1;
        wr_data   = 12'h321;
        clr_valid = 1'b1;
        #1;
        chk_eq("R2", "write held off by clear", int'(wr_ready), 0);
        @(negedge clk);
        wr_valid  = 1'b0;
        clr_valid = 1'b0;
        wait_done(busy);
        chk_eq("R2", "clear taken, no frame", frames - f0, 0);
        chk_eq("R2", "clear taken", clr_pulses - c0, 1);
    endtask

    task automatic t_queued_clear(input logic [11:0] val);
        int l0, c0, d0, busy;
        l0 = ldac_pulses; c0 = clr_pulses; d0 = done_cnt;
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = val;
        @(negedge clk);
        wr_valid = 1'b0;
        for (int k = 0; k < 500; k++) begin
            if (!dac_cs_n && nbits >= 5) break;
            @(negedge clk);
        end
        chk_eq("R10", "clear ready mid frame", int'(clr_ready), 1);
        clr_valid = 1'b1;
        @(negedge clk);
        clr_valid = 1'b0;
        chk_eq("R10", "clear held, ready low", int'(clr_ready), 0);
        chk_eq("R10", "clear not yet driven", int'(dac_clr_n), 1);
        wait_done(busy);
        chk_eq("R10", "frame data kept", int'(last_frame[11:0]), int'(val));
        chk_eq("R10", "load pulse done", ldac_pulses - l0, 1);
        chk_eq("R10", "clear pulse done", clr_pulses - c0, 1);
        chk_eq("R10", "clear after load", int'(t_clr_down > t_ldac_up), 1);
        repeat (6) @(negedge clk);
        chk_eq("R11", "single done for write plus clear", done_cnt - d0, 1);
        chk_eq("R10", "clear ready restored", int'(clr_ready), 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(12'hABC);
        t_write(12'h000);
        t_write(12'hFFF);
        t_write(12'h5A3);
        t_write(12'h801);
        t_clear_idle();
        t_both_idle();
        t_queued_clear(12'h7E4);
        t_write(12'h13F);
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule